// File: doc/BRIEF.md
# Ethernet MAC Address Swapper

This block sits in line on a 64-bit frame stream and returns every frame with its two 6-byte address fields exchanged. The station address that arrived as the sender becomes the destination, and the other way round. All other bytes, the frame boundary markers and the byte-count field leave the block as they arrived. A typical use is a reflector that sends received frames back to where they came from. The frame check sequence is not recomputed, so the trailing CRC of an altered frame no longer matches its contents.

Both the sink and the source side use active-low valid/ready handshakes. A beat moves only in a cycle where its valid and its ready are both low. The two address fields are spread over the first two beats of a frame. The block therefore parks the first beat of a frame in a hold register until the second beat arrives, and then rebuilds both beats. Backpressure from the downstream side reaches the upstream side in the same cycle. Frames shorter than 12 bytes cannot hold both addresses and are forwarded untouched.

Top module: `mac_addr_swap`

## Requirements
- R1: While reset is held and in the first cycle after it, `m_vld_n` is high and `s_rdy_n` is low.
- R2: In the first output beat of a frame of 12 or more bytes, lanes 0 to 5 (lane n is data bits 8n+7 down to 8n, and frame byte 0 sits in lane 0) carry input frame bytes 6 to 11. Lanes 6 and 7 carry input frame bytes 0 and 1.
- R3: In the second output beat of such a frame, lanes 0 to 3 carry input frame bytes 2 to 5. Lanes 4 to 7 carry the second input beat's own lanes 4 to 7.
- R4: Every beat after the second beat of a frame leaves the block with unchanged data.
- R5: A frame of fewer than 12 bytes leaves unchanged. Such a frame is either a single beat with both start and end low, or two beats whose end beat has `s_mty` below 3.
- R6: The start marker, the end marker and the 3-bit `mty` field (valid bytes minus one on the end beat) of each output beat equal those of the corresponding input beat. Beat order is preserved.
- R7: An output beat is transferred only when `m_vld_n` and `m_rdy_n` are both low. While `m_vld_n` is low and `m_rdy_n` is high, the output beat and its markers hold steady.
- R8: Suppose the downstream side is always ready and the upstream side always offers a beat. Then the sink is held off for exactly one cycle in each frame longer than one beat, and for no cycle in single-beat frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_data | input | 64 | Incoming beat data, frame byte order from lane 0 upward |
| s_start_n | input | 1 | Low on the first beat of a frame |
| s_end_n | input | 1 | Low on the last beat of a frame |
| s_mty | input | 3 | Valid bytes minus one on the end beat |
| s_vld_n | input | 1 | Low when the upstream side offers a beat |
| s_rdy_n | output | 1 | Low when the block takes the offered beat |
| m_data | output | 64 | Outgoing beat data |
| m_start_n | output | 1 | Low on the first outgoing beat of a frame |
| m_end_n | output | 1 | Low on the last outgoing beat of a frame |
| m_mty | output | 3 | Valid bytes minus one on the outgoing end beat |
| m_vld_n | output | 1 | Low when an outgoing beat is offered |
| m_rdy_n | input | 1 | Low when the downstream side takes the beat |

## Verification
The framing assertion takes legal input framing for granted. Every frame opens with a start beat, closes with exactly one end beat, and carries no start marker in between. The bench always produces such framing, because it builds each frame from a byte list and marks only its first and last beats. The bench holds every offered beat steady until it is accepted, and it inserts idle cycles only between beats. Downstream readiness is toggled freely, because the block's own checks make no assumption about it.

// File: rtl/mswp_pkg.sv
package mswp_pkg;

    localparam int BYTE_W     = 8;
    localparam int LANES      = 8;
    localparam int DATA_W     = LANES * BYTE_W;
    localparam int MTY_W      = $clog2(LANES);
    localparam int ADDR_BYTES = 6;
    localparam int SWAP_SPAN  = 2 * ADDR_BYTES;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sop;
        logic              eop;
        logic [MTY_W-1:0]  mty;
    } beat_t;

    typedef enum logic [1:0] {
        HOLD_EMPTY,
        HOLD_FIRST,
        HOLD_PEND
    } hold_e;

    // Frame byte index that lands at output byte index i after the exchange.
    function automatic int swap_idx(int i);
        if (i < ADDR_BYTES)
            return i + ADDR_BYTES;
        else if (i < SWAP_SPAN)
            return i - ADDR_BYTES;
        else
            return i;
    endfunction

    // True when a second beat brings the frame to at least SWAP_SPAN bytes.
    function automatic logic reaches_swap(beat_t b);
        return !b.eop || ((LANES + 32'(b.mty) + 1) >= SWAP_SPAN);
    endfunction

endpackage

// File: rtl/mswp_lane_mux.sv
module mswp_lane_mux
    import mswp_pkg::*;
(
    input  beat_t first,
    input  beat_t second,
    output beat_t lead,
    output beat_t follow
);

    logic [2*DATA_W-1:0] pair;
    logic [DATA_W-1:0]   lead_data;
    logic [DATA_W-1:0]   follow_data;

    assign pair = {second.data, first.data};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int SRC_LEAD   = swap_idx(l);
        localparam int SRC_FOLLOW = swap_idx(LANES + l);
        assign lead_data[l*BYTE_W +: BYTE_W]   = pair[SRC_LEAD*BYTE_W +: BYTE_W];
        assign follow_data[l*BYTE_W +: BYTE_W] = pair[SRC_FOLLOW*BYTE_W +: BYTE_W];
    end

    always_comb begin
        lead        = first;
        lead.data   = lead_data;
        follow      = second;
        follow.data = follow_data;
    end

endmodule

// File: rtl/mswp_out_stage.sv
module mswp_out_stage
    import mswp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  beat_t load_beat,
    input  logic  take,
    output logic  vld,
    output beat_t beat,
    output logic  free
);

    logic in_frame;

    assign free = !vld || take;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            beat <= '0;
        end else if (load) begin
            vld  <= 1'b1;
            beat <= load_beat;
        end else if (take) begin
            vld  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            in_frame <= 1'b0;
        else if (vld && take)
            in_frame <= !beat.eop;
    end

    // R7: a stalled beat stays put
    assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (rst)
        (vld && !take) |=> (vld && $stable(beat)));

    // R7: the controller never loads over a beat that has not left
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
        load |-> free);

    // R6: the first beat out after a frame end carries the start marker
    assert_start_after_end_R6: assert property (@(posedge clk) disable iff (rst)
        (vld && take && !in_frame) |-> beat.sop);

endmodule

// File: rtl/mac_addr_swap.sv
module mac_addr_swap
    import mswp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_start_n,
    input  logic              s_end_n,
    input  logic [MTY_W-1:0]  s_mty,
    input  logic              s_vld_n,
    output logic              s_rdy_n,
    output logic [DATA_W-1:0] m_data,
    output logic              m_start_n,
    output logic              m_end_n,
    output logic [MTY_W-1:0]  m_mty,
    output logic              m_vld_n,
    input  logic              m_rdy_n
);

    beat_t in_beat;
    beat_t hold_q, hold_d;
    beat_t lead, follow;
    beat_t load_beat, out_beat;
    hold_e hstate, hstate_d;
    logic  out_vld, out_free, load, ready, s_fire;

    assign in_beat = '{data: s_data, sop: !s_start_n, eop: !s_end_n, mty: s_mty};
    assign ready   = (hstate != HOLD_PEND) && out_free;
    assign s_fire  = ready && !s_vld_n;
    assign s_rdy_n = !ready;

    mswp_lane_mux u_mux (
        .first  (hold_q),
        .second (in_beat),
        .lead   (lead),
        .follow (follow)
    );

    always_comb begin
        hstate_d  = hstate;
        hold_d    = hold_q;
        load      = 1'b0;
        load_beat = hold_q;
        unique case (hstate)
            HOLD_EMPTY: if (s_fire) begin
                if (in_beat.sop && !in_beat.eop) begin
                    hold_d   = in_beat;
                    hstate_d = HOLD_FIRST;
                end else begin
                    load      = 1'b1;
                    load_beat = in_beat;
                end
            end
            HOLD_FIRST: if (s_fire) begin
                load     = 1'b1;
                hstate_d = HOLD_PEND;
                if (reaches_swap(in_beat)) begin
                    load_beat = lead;
                    hold_d    = follow;
                end else begin
                    load_beat = hold_q;
                    hold_d    = in_beat;
                end
            end
            HOLD_PEND: if (out_free) begin
                load      = 1'b1;
                load_beat = hold_q;
                hstate_d  = HOLD_EMPTY;
            end
            default: hstate_d = HOLD_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hstate <= HOLD_EMPTY;
            hold_q <= '0;
        end else begin
            hstate <= hstate_d;
            hold_q <= hold_d;
        end
    end

    mswp_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_beat (load_beat),
        .take      (!m_rdy_n),
        .vld       (out_vld),
        .beat      (out_beat),
        .free      (out_free)
    );

    assign m_data    = out_beat.data;
    assign m_start_n = !out_beat.sop;
    assign m_end_n   = !out_beat.eop;
    assign m_mty     = out_beat.mty;
    assign m_vld_n   = !out_vld;

    // R8: a pending rebuilt beat always has its partner in front of it
    assert_pend_behind_out_R8: assert property (@(posedge clk) disable iff (rst)
        (hstate == HOLD_PEND) |-> out_vld);

    // R8: with the downstream side ready, the pending beat leaves at once
    assert_pend_drains_R8: assert property (@(posedge clk) disable iff (rst)
        ((hstate == HOLD_PEND) && !m_rdy_n) |=> (hstate != HOLD_PEND));

endmodule

// File: tb/sim_mac_addr_swap.sv
`timescale 1ns/1ps
module sim_mac_addr_swap;

    typedef struct {
        logic [63:0] d;
        logic        sop;
        logic        eop;
        logic [2:0]  mty;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] s_data = '0;
    logic        s_start_n = 1'b1, s_end_n = 1'b1;
    logic [2:0]  s_mty = '0;
    logic        s_vld_n = 1'b1;
    logic        s_rdy_n;
    logic [63:0] m_data;
    logic        m_start_n, m_end_n;
    logic [2:0]  m_mty;
    logic        m_vld_n;
    logic        m_rdy_n = 1'b0;

    int   checks = 0, fails = 0;
    exp_t q[$];
    logic bp_en = 1'b0, gap_en = 1'b0, stall_en = 1'b0;
    int   stalls = 0, exp_stalls = 0;
    logic stall_prev = 1'b0;
    logic [69:0] saved;
    logic done = 1'b0;

    always #2 clk = ~clk;

    mac_addr_swap u0 (
        .clk(clk), .rst(rst),
        .s_data(s_data), .s_start_n(s_start_n), .s_end_n(s_end_n), .s_mty(s_mty),
        .s_vld_n(s_vld_n), .s_rdy_n(s_rdy_n),
        .m_data(m_data), .m_start_n(m_start_n), .m_end_n(m_end_n), .m_mty(m_mty),
        .m_vld_n(m_vld_n), .m_rdy_n(m_rdy_n)
    );

    always @(posedge clk) begin
        #1;
        m_rdy_n = bp_en ? (($urandom % 3) == 0) : 1'b0;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev) begin
                checks++;
                if ({m_data, m_start_n, m_end_n, m_mty, m_vld_n} != saved) begin
                    fails++;
                    $display("FAIL R7 stalled beat changed: got %h exp %h",
                             {m_data, m_start_n, m_end_n, m_mty, m_vld_n}, saved);
                end
            end
            stall_prev = !m_vld_n && m_rdy_n;
            saved = {m_data, m_start_n, m_end_n, m_mty, m_vld_n};
            if (stall_en && !s_vld_n && s_rdy_n) stalls++;
            if (!m_vld_n && !m_rdy_n) begin
                if (q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R6 unexpected beat: got %h exp none", m_data);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    checks++;
                    if (m_data !== e.d) begin
                        fails++;
                        $display("FAIL %s data: got %h exp %h", e.req, m_data, e.d);
                    end
                    checks++;
                    if ({!m_start_n, !m_end_n, m_mty} !== {e.sop, e.eop, e.mty}) begin
                        fails++;
                        $display("FAIL R6 markers: got %b exp %b",
                                 {!m_start_n, !m_end_n, m_mty}, {e.sop, e.eop, e.mty});
                    end
                end
            end
        end
    end

    task automatic send_frame(int n);
        logic [7:0] fb[$];
        logic [7:0] ex[$];
        int nb;
        for (int i = 0; i < n; i++) fb.push_back(8'($urandom));
        ex = fb;
        if (n >= 12) begin
            for (int i = 0; i < 6; i++) begin
                ex[i]   = fb[i+6];
                ex[i+6] = fb[i];
            end
        end
        if (n > 8) exp_stalls++;
        nb = (n + 7) / 8;
        for (int k = 0; k < nb; k++) begin
            exp_t e;
            logic [63:0] din;
            for (int l = 0; l < 8; l++) begin
                din[l*8 +: 8] = (8*k + l < n) ? fb[8*k+l] : 8'hA5;
                e.d[l*8 +: 8] = (8*k + l < n) ? ex[8*k+l] : 8'hA5;
            end
            e.sop = (k == 0);
            e.eop = (k == nb - 1);
            e.mty = e.eop ? 3'((n - 1) % 8) : 3'd7;
            e.req = (n < 12) ? "R5" : (k == 0) ? "R2" : (k == 1) ? "R3" : "R4";
            q.push_back(e);
            s_data = din; s_start_n = !e.sop; s_end_n = !e.eop; s_mty = e.mty;
            s_vld_n = 1'b0;
            forever begin
                @(negedge clk);
                if (!s_rdy_n) break;
            end
            @(posedge clk); #1;
            s_vld_n = 1'b1;
            if (gap_en && ($urandom % 4 == 0)) begin
                @(posedge clk); #1;
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && q.size() != 0; i++) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R4 beats missing: got %0d left exp 0", q.size());
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        checks++;
        if (m_vld_n !== 1'b1) begin
            fails++; $display("FAIL R1 m_vld_n in reset: got %b exp 1", m_vld_n);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (m_vld_n !== 1'b1) begin
            fails++; $display("FAIL R1 m_vld_n after reset: got %b exp 1", m_vld_n);
        end
        checks++;
        if (s_rdy_n !== 1'b0) begin
            fails++; $display("FAIL R1 s_rdy_n after reset: got %b exp 0", s_rdy_n);
        end
        @(posedge clk); #1;

        // R8 phase: downstream always ready, upstream back to back
        stall_en = 1'b1;
        send_frame(64); send_frame(12); send_frame(1); send_frame(11);
        send_frame(9);  send_frame(8);  send_frame(16); send_frame(100);
        stall_en = 1'b0;
        drain();
        checks++;
        if (stalls != exp_stalls) begin
            fails++;
            $display("FAIL R8 sink stall cycles: got %0d exp %0d", stalls, exp_stalls);
        end

        // R7 / R2..R6 phase with backpressure and idle gaps
        bp_en = 1'b1; gap_en = 1'b1;
        send_frame(13); send_frame(60); send_frame(10); send_frame(12);
        send_frame(7);  send_frame(200); send_frame(24); send_frame(4);
        for (int f = 0; f < 20; f++) send_frame(1 + int'($urandom % 90));
        bp_en = 1'b0; gap_en = 1'b0;
        drain();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

endmodule